// File: doc/BRIEF.md
# Triggered Byte Pattern Streamer

This block plays a prepared stream of bit patterns onto a narrow parallel bus. A host pushes 32-bit words into an eight-entry FIFO through a valid/ready write port. From reset the six output pins sit at zero. The block waits for a start flag that a one-cycle trigger pulse sets. When it sees the flag it clears the flag and starts streaming. From then on it keeps streaming and never looks at the trigger again.

Each word is cut into four bytes and sent lowest byte first. The bus carries the low six bits of the current byte, and the top two bits of each byte are dropped. A programmable divider sets the pace: it makes one tick every N system clocks. Each byte takes two ticks, an update tick followed by a rest tick. When the four bytes of a word are used up, the next word is taken from the FIFO. If the FIFO is empty at that point, the bus keeps its last value. The stream carries on with the next update tick after a word arrives.

Top module: `pattern_streamer`

## Requirements
- R1: From reset until the trigger is accepted, `pins` is 0, whatever the FIFO holds.
- R2: A high `trig_pulse` at a clock edge sets `trig_flag` after that edge. While the block is waiting, a set flag is accepted at the next edge: `trig_flag` goes back to 0 and streaming starts. If a new pulse arrives on the edge where the flag is accepted, that pulse is absorbed.
- R3: Once streaming has started, it never stops. Later trigger pulses set `trig_flag`, which then stays set, and they have no effect on `pins`.
- R4: Ticks fall on edge number k·N after the acceptance edge (k = 1, 2, …). The first tick is an update tick, and after that the ticks alternate between update and rest. The bytes of a word appear in this order: bits 7:0, then 15:8, then 23:16, then 31:24.
- R5: `pins` changes only on an update tick, so each byte is held for two ticks (2·N clocks) while data keeps coming.
- R6: `pins` = bits 5:0 of the current byte. Bits 7:6 are never seen.
- R7: A word is popped only on an update tick that needs a new word. Its byte 0 appears on that same edge. Words leave the FIFO in the order they were accepted. A word written on an edge can be used from the next edge on.
- R8: If an update tick needs a word and the FIFO is empty, `pins` keeps its value. The block stays in the update slot, and the first tick after a word arrives sends byte 0 of that word.
- R9: The FIFO holds 8 words. `fifo_full` is high when 8 words are stored, and `wr_ready` = !`fifo_full`. A word is stored only when `wr_valid` and `wr_ready` are both high, and a write offered while the FIFO is full is dropped.
- R10: N = `div_n`, except that `div_n` = 0 acts as 1. With N = 1 there is a tick on every clock. `div_n` is held steady while streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Host offers a word |
| wr_data | input | 32 | Word offered by the host |
| wr_ready | output | 1 | FIFO can take a word |
| fifo_full | output | 1 | FIFO holds 8 words |
| trig_pulse | input | 1 | Sets the start flag |
| trig_flag | output | 1 | Start flag state |
| div_n | input | 16 | Clocks per tick (0 acts as 1) |
| pins | output | 6 | Parallel pattern output |

## Verification
A directed word whose bytes have their top bits set is sent at N = 1. It shows whether the byte order is right, whether bits 7:6 get through, and whether the rest tick holds the bus. After it comes a drained FIFO, which separates a true stall from stale or made-up output. A preload that keeps writing into a full FIFO separates dropped writes from lost or duplicated words. Random traffic with gaps runs at divider values of 0, 1, 3 and 5, with stray trigger pulses mixed in. This shows whether tick spacing, the phase kept across a stall, and the trigger being ignored after the start all follow the model kept in the bench.

// File: rtl/stream_pkg.sv
package stream_pkg;
    localparam int WORD_W_DEF  = 32;
    localparam int BYTE_W_DEF  = 8;
    localparam int PIN_W_DEF   = 6;
    localparam int DIV_W_DEF   = 16;
    localparam int DEPTH_DEF   = 8;

    typedef enum logic {
        PH_DRIVE = 1'b0,
        PH_REST  = 1'b1
    } phase_e;
endpackage

// File: rtl/stream_fifo.sv
module stream_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [W-1:0]                 in_data,
    output logic                         in_ready,
    output logic                         full,
    input  logic                         pop,
    output logic [W-1:0]                 out_data,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;
    logic [W-1:0] mem_q [DEPTH];
    logic push, take;

    assign full     = (st_q.cnt == CW'(DEPTH));
    assign empty    = (st_q.cnt == '0);
    assign in_ready = !full;
    assign out_data = mem_q[st_q.rp];
    assign count    = st_q.cnt;

    always_comb begin
        st_d = st_q;
        push = in_valid && !full;
        take = pop && !empty;
        if (push) st_d.wp = (st_q.wp == LAST) ? '0 : st_q.wp + AW'(1);
        if (take) st_d.rp = (st_q.rp == LAST) ? '0 : st_q.rp + AW'(1);
        st_d.cnt = st_q.cnt + CW'(push) - CW'(take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[st_q.wp] <= in_data;
    end
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_st_t;

    div_st_t st_q, st_d;
    logic [DIV_W-1:0] limit_m1;

    always_comb begin
        st_d     = st_q;
        limit_m1 = (div_n == '0) ? '0 : div_n - DIV_W'(1);
        tick     = run && (st_q.cnt >= limit_m1);
        if (!run)      st_d.cnt = '0;
        else if (tick) st_d.cnt = '0;
        else           st_d.cnt = st_q.cnt + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/trig_latch.sv
module trig_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_pulse,
    output logic flag,
    output logic run
);
    typedef struct packed {
        logic flag;
        logic run;
    } trig_st_t;

    trig_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        st_d.flag = st_q.flag | trig_pulse;
        if (!st_q.run && st_q.flag) begin
            st_d.run  = 1'b1;
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign run  = st_q.run;
endmodule

// File: rtl/byte_unpacker.sv
module byte_unpacker
    import stream_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int PIN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_data,
    output logic              pop,
    output logic [PIN_W-1:0]  pins
);
    localparam int SLOTS = WORD_W / BYTE_W;
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [IDX_W-1:0]  idx;
        logic              have;
        phase_e            phase;
        logic [PIN_W-1:0]  pins;
    } unp_st_t;

    unp_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (tick) begin
            if (st_q.phase == PH_DRIVE) begin
                if (st_q.have) begin
                    st_d.pins  = st_q.word[st_q.idx*BYTE_W +: PIN_W];
                    st_d.idx   = st_q.idx + IDX_W'(1);
                    st_d.have  = (st_q.idx != LAST_IDX);
                    st_d.phase = PH_REST;
                end else if (!fifo_empty) begin
                    pop        = 1'b1;
                    st_d.word  = fifo_data;
                    st_d.pins  = fifo_data[PIN_W-1:0];
                    st_d.idx   = IDX_W'(1);
                    st_d.have  = (SLOTS > 1);
                    st_d.phase = PH_REST;
                end
            end else begin
                st_d.phase = PH_DRIVE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{word: '0, idx: '0, have: 1'b0, phase: PH_DRIVE, pins: '0};
        else        st_q <= st_d;
    end

    assign pins = st_q.pins;
endmodule

// File: rtl/pattern_streamer.sv
module pattern_streamer
    import stream_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int BYTE_W = BYTE_W_DEF,
    parameter int PIN_W  = PIN_W_DEF,
    parameter int DIV_W  = DIV_W_DEF,
    parameter int DEPTH  = DEPTH_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              fifo_full,
    input  logic              trig_pulse,
    output logic              trig_flag,
    input  logic [DIV_W-1:0]  div_n,
    output logic [PIN_W-1:0]  pins
);
    localparam int CW = $clog2(DEPTH + 1);

    logic              run_w, tick_w, pop_w, empty_w;
    logic [WORD_W-1:0] head_w;
    logic [CW-1:0]     fifo_cnt_w;

    stream_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (wr_valid),
        .in_data  (wr_data),
        .in_ready (wr_ready),
        .full     (fifo_full),
        .pop      (pop_w),
        .out_data (head_w),
        .empty    (empty_w),
        .count    (fifo_cnt_w)
    );

    trig_latch u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_pulse (trig_pulse),
        .flag       (trig_flag),
        .run        (run_w)
    );

    tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_w),
        .div_n (div_n),
        .tick  (tick_w)
    );

    byte_unpacker #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .PIN_W(PIN_W)) u_unp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_w),
        .fifo_empty (empty_w),
        .fifo_data  (head_w),
        .pop        (pop_w),
        .pins       (pins)
    );
endmodule

// File: rtl/pattern_streamer_chk.sv
module pattern_streamer_chk #(
    parameter int PIN_W = 6,
    parameter int DIV_W = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             flag,
    input logic             tick,
    input logic [PIN_W-1:0] pins,
    input logic             full,
    input logic             wr_ready,
    input logic [DIV_W-1:0] div_n,
    input logic [CW-1:0]    count
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> pins == '0);

    assert_accept_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && flag) |=> (run && !flag));

    assert_no_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> run);

    assert_hold_off_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pins));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !wr_ready);

    assert_tick_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div_n > DIV_W'(1)) |=> !tick);
endmodule

bind pattern_streamer pattern_streamer_chk #(
    .PIN_W(PIN_W), .DIV_W(DIV_W), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .flag     (trig_flag),
    .tick     (tick_w),
    .pins     (pins),
    .full     (fifo_full),
    .wr_ready (wr_ready),
    .div_n    (div_n),
    .count    (fifo_cnt_w)
);

// File: tb/pattern_streamer_test.sv
`timescale 1ns/1ps
module pattern_streamer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready, fifo_full, trig_flag;
    logic        trig_pulse = 1'b0;
    logic [15:0] div_n = 16'd1;
    logic [5:0]  pins;

    always #2.5 clk = ~clk;

    pattern_streamer uut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .fifo_full(fifo_full), .trig_pulse(trig_pulse),
        .trig_flag(trig_flag), .div_n(div_n), .pins(pins)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model of the requirements
    bit          running, rest_slot, have;
    int          n_eff, edges, idx;
    logic [31:0] cur;
    logic [5:0]  exp_pins;
    bit          exp_flag;
    logic [31:0] q[$];
    bit          s_v, s_rdy, s_t, s_flag;
    logic [31:0] s_d;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #950000;
        checks++; errors++;
        $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        running = 0; rest_slot = 0; have = 0; edges = 0; idx = 0;
        cur = '0; exp_pins = '0; exp_flag = 0; q.delete();
    endtask

    task automatic model_edge();
        bit accept;
        accept = !running && s_flag;
        if (running) begin
            edges++;
            if (edges % n_eff == 0) begin
                if (!rest_slot) begin
                    if (have) begin
                        exp_pins = cur[idx*8 +: 6];
                        idx++;
                        if (idx == 4) have = 0;
                        rest_slot = 1;
                    end else if (q.size() > 0) begin
                        cur = q.pop_front();
                        exp_pins = cur[5:0];
                        idx = 1; have = 1;
                        rest_slot = 1;
                    end
                end else begin
                    rest_slot = 0;
                end
            end
        end
        exp_flag = accept ? 1'b0 : (exp_flag | s_t);
        if (accept) begin
            running = 1; edges = 0;
        end
        if (s_v && s_rdy) q.push_back(s_d);
    endtask

    task automatic compare();
        if (running) chk(pins == exp_pins, "R4/R5/R6/R7/R8/R10 pins", pins, exp_pins);
        else         chk(pins == 6'd0, "R1 pins idle", pins, 0);
        chk(trig_flag == exp_flag, running ? "R3 flag" : "R2 flag", trig_flag, exp_flag);
        chk(fifo_full == (q.size() == 8), "R9 full", fifo_full, q.size() == 8);
        chk(wr_ready == (q.size() != 8), "R9 ready", wr_ready, q.size() != 8);
    endtask

    task automatic cyc(bit v, logic [31:0] d, bit t);
        wr_valid = v; wr_data = d; trig_pulse = t;
        s_v = v; s_rdy = wr_ready; s_d = d; s_t = t; s_flag = trig_flag;
        @(negedge clk);
        model_edge();
        compare();
    endtask

    task automatic do_reset(int div);
        rst_n = 0; wr_valid = 0; trig_pulse = 0; div_n = 16'(div);
        n_eff = (div == 0) ? 1 : div;
        repeat (3) @(negedge clk);
        chk(pins == 6'd0, "R1 reset pins", pins, 0);
        chk(trig_flag == 1'b0, "R2 reset flag", trig_flag, 0);
        chk(wr_ready == 1'b1, "R9 reset ready", wr_ready, 1);
        chk(fifo_full == 1'b0, "R9 reset full", fifo_full, 0);
        rst_n = 1;
        model_reset();
    endtask

    task automatic random_run(int cycles, int pct, int trig_odds);
        for (int i = 0; i < cycles; i++) begin
            bit v, t;
            v = ($urandom % 100) < pct;
            t = (trig_odds > 0) && (($urandom % trig_odds) == 0);
            cyc(v, $urandom, t);
        end
    endtask

    initial begin
        void'($urandom(32'd20250225));

        // S1: directed word at N=1, top bits dropped, then underrun
        do_reset(1);
        cyc(1, 32'hA57EC0C3, 0);
        for (int i = 0; i < 5; i++) cyc(0, '0, 0);
        chk(pins == 6'd0, "R1 data waiting but no trigger", pins, 0);
        cyc(0, '0, 1);
        chk(trig_flag == 1'b1, "R2 flag set", trig_flag, 1);
        cyc(0, '0, 0);
        chk(trig_flag == 1'b0, "R2 flag cleared on accept", trig_flag, 0);
        cyc(0, '0, 0);
        chk(pins == 6'h03, "R6 byte 0 low bits", pins, 6'h03);
        cyc(0, '0, 0);
        chk(pins == 6'h03, "R5 rest tick holds", pins, 6'h03);
        cyc(0, '0, 0);
        chk(pins == 6'h00, "R4 byte 1", pins, 6'h00);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        chk(pins == 6'h3E, "R4 byte 2", pins, 6'h3E);
        cyc(0, '0, 0);
        cyc(0, '0, 0);
        chk(pins == 6'h25, "R7 byte 3", pins, 6'h25);
        for (int i = 0; i < 20; i++) cyc(0, '0, 0);
        chk(pins == 6'h25, "R8 stall keeps last value", pins, 6'h25);
        cyc(1, 32'h00000011, 0);
        cyc(0, '0, 0);
        chk(pins == 6'h11, "R8 resume on first tick", pins, 6'h11);
        random_run(1000, 30, 60);

        // S2: fill past full before trigger, N=3
        do_reset(3);
        for (int i = 0; i < 12; i++) cyc(1, 32'h01020300 + 32'(i), 0);
        chk(fifo_full == 1'b1, "R9 full after excess writes", fifo_full, 1);
        chk(pins == 6'd0, "R1 full fifo, no trigger", pins, 0);
        cyc(0, '0, 1);
        random_run(1200, 20, 100);
        chk(trig_flag == exp_flag, "R3 late pulses ignored", trig_flag, exp_flag);

        // S3: divider zero acts as one
        do_reset(0);
        cyc(0, '0, 1);
        random_run(1000, 25, 0);

        // S4: slow divider with sparse data, many stalls
        do_reset(5);
        cyc(1, $urandom, 0);
        cyc(0, '0, 1);
        random_run(1500, 3, 150);

        finish_run();
    end
endmodule